// File: doc/BRIEF.md
# Link Frame Assembler

This block turns a request from a host core into a byte stream for an outgoing link frame. With one start pulse the host hands over a payload length of zero to seven 16-bit words, the payload words themselves, a label-enable flag with a 16-bit label, and a CRC-enable flag. The block keeps a copy of all of them. It then sends the frame body one byte at a time over a valid/ready handshake. It also raises a one-cycle request asking the command channel to send the frame header symbol.

The body always starts with a length/type byte: the 3-bit length and the label flag, protected by a Hamming(8,4) code. The label follows if the flag is set, then the payload, then a CRC-16 of the payload if CRC is enabled. All multi-byte fields go out high byte first. The payload is opaque: its bits go out unchanged. A start request that arrives while a frame is still going out is dropped and counted in a saturating counter.

Top module: `frame_asm`

## Requirements
- R1: A start request seen while the block is idle is accepted at that clock edge. `hdr_req_o` is then high for exactly the one cycle after that edge.
- R2: The bytes of a frame go out in this order: the length/type byte, then the label high and low bytes (only when `label_en_i` was 1), then the payload, then the CRC high and low bytes (only when `crc_en_i` was 1).
- R3: The length/type byte is {d3,d2,d1,d0,p1,p2,p3,p0}, with bit 7 first in that list. Here {d3,d2,d1} = `len_i` and d0 = `label_en_i`. The parity bits are p1 = d3^d2^d0, p2 = d3^d1^d0 and p3 = d2^d1^d0. p0 is the XOR of the other seven bits, so the byte has even parity.
- R4: The CRC is CRC-16 with polynomial 0x1021, seeded with 0xFFFF. It runs MSB first over the payload bytes in the order they are sent. With zero payload words it is 0xFFFF.
- R5: `out_valid_o` is low whenever the block is idle. A byte held with `out_valid_o` high and `out_ready_i` low stays stable. The stream moves to the next byte only on a cycle where both are high.
- R6: Payload word k sits in `payload_i[16k+15:16k]`, and words go out in the order k = 0 up to len-1, each high byte first. Every bit pattern goes out unchanged.
- R7: A start request while `busy_o` is high is ignored: the frame in progress and the values captured for it do not change. Each such request adds one to `rej_cnt_o`, which stops at its maximum value.
- R8: `busy_o` goes high in the cycle after acceptance. It goes low in the cycle after the handshake of the last byte of the frame.
- R9: After reset `out_valid_o`, `hdr_req_o` and `busy_o` are low and `rej_cnt_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request |
| len_i | input | 3 | Payload length in 16-bit words |
| label_en_i | input | 1 | Send the label |
| label_i | input | 16 | Frame label |
| crc_en_i | input | 1 | Append the payload CRC |
| payload_i | input | 112 | Payload words, word 0 in the low bits |
| out_data_o | output | 8 | Stream byte |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Downstream ready |
| hdr_req_o | output | 1 | Header command request strobe |
| busy_o | output | 1 | Frame in progress |
| rej_cnt_o | output | REJ_W (8) | Count of ignored start requests (saturating) |

## Verification
The bench builds the block with REJ_W set to 3. The reject counter then tops out at 7, so a short burst of start requests during a long frame drives it into saturation and checks that it holds there. The payload length is fixed at 0 to 7 words by the field, so the bench sweeps every length under every label and CRC combination. It does this once with ready always high and once with random back-pressure. That covers the empty-payload CRC, the longest frame and all the stall cases.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int MAX_WORDS = 7;
  localparam int LEN_W     = 3;
  localparam int WORD_W    = 16;
  localparam int PB_MAX    = 2 * MAX_WORDS;
  localparam int PIDX_W    = $clog2(PB_MAX);
  localparam int PAY_W     = MAX_WORDS * WORD_W;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FLT, PH_LAB_HI, PH_LAB_LO, PH_PAY, PH_CRC_HI, PH_CRC_LO
  } phase_t;

  // Hamming(8,4): {d3,d2,d1,d0,p1,p2,p3,p0}, p0 makes even overall parity
  function automatic logic [7:0] flt_encode(input logic [LEN_W-1:0] len,
                                            input logic lab);
    logic d3, d2, d1, d0, p1, p2, p3;
    logic [6:0] body;
    d3 = len[2]; d2 = len[1]; d1 = len[0]; d0 = lab;
    p1 = d3 ^ d2 ^ d0;
    p2 = d3 ^ d1 ^ d0;
    p3 = d2 ^ d1 ^ d0;
    body = {d3, d2, d1, d0, p1, p2, p3};
    return {body, ^body};
  endfunction

  function automatic logic [15:0] crc16_byte(input logic [15:0] c,
                                             input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction
endpackage

// File: rtl/fa_flt_enc.sv
module fa_flt_enc
  import fa_pkg::*;
(
  input  logic [LEN_W-1:0] len_i,
  input  logic             lab_i,
  output logic [7:0]       code_o
);
  always_comb code_o = flt_encode(len_i, lab_i);
endmodule

// File: rtl/fa_crc_unit.sv
module fa_crc_unit
  import fa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  din_i,
  output logic [15:0] crc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_o <= CRC_SEED;
    else if (clear_i) crc_o <= CRC_SEED;
    else if (en_i)    crc_o <= crc16_byte(crc_o, din_i);
  end
endmodule

// File: rtl/fa_rej_counter.sv
module fa_rej_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CMAX) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/fa_byte_pick.sv
module fa_byte_pick
  import fa_pkg::*;
(
  input  logic [PAY_W-1:0]  words_i,
  input  logic [PIDX_W-1:0] idx_i,
  output logic [7:0]        byte_o
);
  logic [7:0] bytes [PB_MAX];

  for (genvar g = 0; g < PB_MAX; g++) begin : g_slot
    localparam int WI = g / 2;
    localparam int HI = (g % 2 == 0) ? 15 : 7;
    assign bytes[g] = words_i[WI*WORD_W + HI -: 8];
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < PB_MAX; i++)
      if (idx_i == PIDX_W'(i)) byte_o = bytes[i];
  end
endmodule

// File: rtl/frame_asm.sv
module frame_asm
  import fa_pkg::*;
#(
  parameter int REJ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        len_i,
  input  logic              label_en_i,
  input  logic [15:0]       label_i,
  input  logic              crc_en_i,
  input  logic [111:0]      payload_i,
  output logic [7:0]        out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              hdr_req_o,
  output logic              busy_o,
  output logic [REJ_W-1:0]  rej_cnt_o
);
  phase_t              phase_q, phase_d;
  logic [PIDX_W-1:0]   pidx_q;
  logic [LEN_W-1:0]    len_q;
  logic                lab_q, crcen_q;
  logic [15:0]         label_q;
  logic [PAY_W-1:0]    pay_q;
  logic                hdr_q;

  // named events for the checker
  logic        accept, reject, xfer, flt_slot, pay_step, frame_done, pay_last;
  logic [7:0]  flt_code, pay_byte;
  logic [15:0] crc_val;
  logic [PIDX_W-1:0] pay_end;

  assign busy_o      = (phase_q != PH_IDLE);
  assign out_valid_o = busy_o;
  assign hdr_req_o   = hdr_q;
  assign accept      = start_i && !busy_o;
  assign reject      = start_i && busy_o;
  assign xfer        = out_valid_o && out_ready_i;
  assign flt_slot    = (phase_q == PH_FLT);
  assign pay_step    = xfer && (phase_q == PH_PAY);
  assign pay_end     = PIDX_W'({len_q, 1'b0}) - PIDX_W'(1);
  assign pay_last    = (pidx_q == pay_end);
  assign frame_done  = xfer && (phase_d == PH_IDLE);

  fa_flt_enc u_flt (.len_i(len_q), .lab_i(lab_q), .code_o(flt_code));

  fa_byte_pick u_pick (.words_i(pay_q), .idx_i(pidx_q), .byte_o(pay_byte));

  fa_crc_unit u_crc (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .en_i(pay_step),
    .din_i(pay_byte), .crc_o(crc_val)
  );

  fa_rej_counter #(.W(REJ_W)) u_rej (
    .clk(clk), .rst_n(rst_n), .inc_i(reject), .cnt_o(rej_cnt_o)
  );

  phase_t after_pay, after_lab, after_flt;
  always_comb begin
    after_pay = crcen_q ? PH_CRC_HI : PH_IDLE;
    after_lab = (len_q != '0) ? PH_PAY : after_pay;
    after_flt = lab_q ? PH_LAB_HI : after_lab;
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (accept) phase_d = PH_FLT;
      PH_FLT:    if (xfer) phase_d = after_flt;
      PH_LAB_HI: if (xfer) phase_d = PH_LAB_LO;
      PH_LAB_LO: if (xfer) phase_d = after_lab;
      PH_PAY:    if (xfer && pay_last) phase_d = after_pay;
      PH_CRC_HI: if (xfer) phase_d = PH_CRC_LO;
      PH_CRC_LO: if (xfer) phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (phase_q)
      PH_FLT:    out_data_o = flt_code;
      PH_LAB_HI: out_data_o = label_q[15:8];
      PH_LAB_LO: out_data_o = label_q[7:0];
      PH_PAY:    out_data_o = pay_byte;
      PH_CRC_HI: out_data_o = crc_val[15:8];
      PH_CRC_LO: out_data_o = crc_val[7:0];
      default:   out_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      pidx_q  <= '0;
      len_q   <= '0;
      lab_q   <= 1'b0;
      crcen_q <= 1'b0;
      label_q <= '0;
      pay_q   <= '0;
      hdr_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      hdr_q   <= accept;
      if (accept) begin
        pidx_q  <= '0;
        len_q   <= len_i;
        lab_q   <= label_en_i;
        crcen_q <= crc_en_i;
        label_q <= label_i;
        pay_q   <= payload_i;
      end else if (pay_step) begin
        pidx_q <= pidx_q + PIDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/frame_asm_checker.sv
module frame_asm_checker #(
  parameter int REJ_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [7:0]       out_data_o,
  input logic             hdr_req_o,
  input logic [REJ_W-1:0] rej_cnt_o,
  input logic             flt_slot,
  input logic [15:0]      crc_val
);
  localparam logic [REJ_W-1:0] RMAX = {REJ_W{1'b1}};

  AST_HDR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_req_o |=> !hdr_req_o); // R1
  AST_ACCEPT_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (hdr_req_o && busy_o)); // R8
  AST_FLT_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> flt_slot); // R2
  AST_FLT_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    flt_slot |-> !(^out_data_o)); // R3
  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    flt_slot |-> (crc_val == 16'hFFFF)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !out_valid_o); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R5
  AST_REJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && rej_cnt_o != RMAX) |=>
      (rej_cnt_o == $past(rej_cnt_o) + {{(REJ_W-1){1'b0}}, 1'b1})); // R7
  AST_REJ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && busy_o) |=> $stable(rej_cnt_o)); // R7
endmodule

bind frame_asm frame_asm_checker #(.REJ_W(REJ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .hdr_req_o(hdr_req_o), .rej_cnt_o(rej_cnt_o),
  .flt_slot(flt_slot), .crc_val(crc_val)
);

// File: tb/frame_asm_bench.sv
module frame_asm_bench;
  localparam int REJ_W = 3;
  localparam int REJ_MAX = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, label_en_i = 1'b0, crc_en_i = 1'b0, out_ready_i = 1'b0;
  logic [2:0] len_i = '0;
  logic [15:0] label_i = '0;
  logic [111:0] payload_i = '0;
  logic [7:0] out_data_o;
  logic out_valid_o, hdr_req_o, busy_o;
  logic [REJ_W-1:0] rej_cnt_o;

  always #4 clk = ~clk;

  frame_asm #(.REJ_W(REJ_W)) u_frame_asm (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] expq[$];
  string tagq[$];
  bit hdr_exp = 0;
  int rej_exp = 0;
  int rdy_pct = 100;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(logic [7:0] bytes[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (bytes[n])
      for (int i = 7; i >= 0; i--) begin
        bit fb = c[15] ^ bytes[n][i];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  function automatic logic [7:0] ref_flt(logic [2:0] len, logic lab);
    logic [3:0] d = {len, lab};
    logic [6:0] s = {d, ^(d & 4'b1101), ^(d & 4'b1011), ^(d & 4'b0111)};
    return {s, ^s};
  endfunction

  function automatic void push(logic [7:0] b, string t);
    expq.push_back(b);
    tagq.push_back(t);
  endfunction

  // one clock: check at the negedge, then drive for the next edge
  task automatic cycle(bit st, logic [2:0] ln, bit le, logic [15:0] lb,
                       bit ce, logic [111:0] pl);
    bit busy_edge;
    @(negedge clk);
    if (expq.size() > 0) begin
      chk(out_valid_o == 1'b1, "R5 valid", out_valid_o, 1);
      chk(out_data_o == expq[0], tagq[0], out_data_o, expq[0]);
    end else begin
      chk(out_valid_o == 1'b0, "R5 idle valid", out_valid_o, 0);
    end
    chk(busy_o == (expq.size() > 0), "R8 busy", busy_o, expq.size() > 0);
    chk(hdr_req_o == hdr_exp, "R1 hdr_req", hdr_req_o, hdr_exp);
    chk(int'(rej_cnt_o) == rej_exp, "R7 rej_cnt", rej_cnt_o, rej_exp);
    busy_edge = expq.size() > 0;
    hdr_exp = 0;
    out_ready_i = ($urandom_range(99) < rdy_pct);
    if (busy_edge && out_ready_i) begin
      void'(expq.pop_front());
      void'(tagq.pop_front());
    end
    start_i = st; len_i = ln; label_en_i = le; label_i = lb;
    crc_en_i = ce; payload_i = pl;
    if (st) begin
      if (busy_edge) begin
        if (rej_exp < REJ_MAX) rej_exp++;
      end else begin
        logic [7:0] pb[$];
        hdr_exp = 1;
        push(ref_flt(ln, le), "R3 flt");
        if (le) begin push(lb[15:8], "R2 label"); push(lb[7:0], "R2 label"); end
        for (int k = 0; k < ln; k++) begin
          pb.push_back(pl[16*k+8 +: 8]);
          pb.push_back(pl[16*k +: 8]);
        end
        foreach (pb[n]) push(pb[n], "R6 payload");
        if (ce) begin
          logic [15:0] c = ref_crc(pb);
          push(c[15:8], "R4 crc");
          push(c[7:0], "R4 crc");
        end
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, '0, 0, '0, 0, '0);
  endtask

  task automatic drain();
    while (expq.size() > 0) idle(1);
    idle(1);
  endtask

  function automatic logic [111:0] rnd_pay();
    logic [111:0] p;
    for (int i = 0; i < 4; i++) p[32*i +: 32] = $urandom();
    return p;
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none

    // R9: reset state
    repeat (2) @(negedge clk);
    chk(!out_valid_o && !hdr_req_o && !busy_o, "R9 reset outputs",
        {out_valid_o, hdr_req_o, busy_o}, 0);
    chk(rej_cnt_o == '0, "R9 reset count", rej_cnt_o, 0);
    rst_n = 1'b1;
    idle(3);

    // R2 R3 R4 R6: every length and option combination, two ready patterns
    for (int pass = 0; pass < 2; pass++) begin
      rdy_pct = (pass == 0) ? 100 : 50;
      for (int ln = 0; ln < 8; ln++)
        for (int opt = 0; opt < 4; opt++) begin
          cycle(1, 3'(ln), opt[0], 16'($urandom()), opt[1], rnd_pay());
          drain();
        end
    end

    // R6: extreme payload patterns pass unchanged
    rdy_pct = 70;
    cycle(1, 3'd7, 1, 16'hFFFF, 1, {112{1'b1}}); drain();
    cycle(1, 3'd7, 1, 16'h0000, 1, '0); drain();
    cycle(1, 3'd7, 0, 16'h0000, 1, {56{2'b10}}); drain();

    // R4: empty payload with CRC gives the seed 0xFFFF
    cycle(1, 3'd0, 0, 16'h0, 1, '0); drain();

    // R7: starts while busy are ignored, counted and saturate
    rdy_pct = 30;
    cycle(1, 3'd7, 1, 16'hA55A, 1, rnd_pay());
    for (int i = 0; i < 9; i++)
      cycle(1, 3'($urandom()), 1'($urandom()), 16'h1234, 1'($urandom()), rnd_pay());
    drain();
    chk(int'(rej_cnt_o) == REJ_MAX, "R7 saturated", rej_cnt_o, REJ_MAX);

    // R1 R8: back-to-back frames started right after the previous one ends
    rdy_pct = 100;
    cycle(1, 3'd1, 0, 16'h0, 0, rnd_pay()); drain();
    cycle(1, 3'd0, 0, 16'h0, 0, '0); drain();
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule